// File: doc/BRIEF.md
# Dual-Byte Running Disparity Predictor

This block sits ahead of an 8b/10b encoder that accepts a forced disparity value for each byte but does not report the running disparity it reaches. Each cycle it may receive a 16-bit transmit word, one control flag per byte and a valid strobe. The low byte goes to one registered lookup table and the high byte to a second one. Each table answers one question: would the 10-bit code for this byte invert the running disparity? The words themselves pass through a matching one-cycle delay.

One cycle after a word is accepted, the block outputs the word together with three disparity bits. The low byte is forced to the disparity carried over from the previous word. The high byte is forced to that value after the low byte's flip. The end-of-word disparity also includes the high byte's flip, and it is carried into the next valid word.

An idle request replaces the word with the IDLE ordered set that suits the carried disparity. That ordered set is a comma on the low lane, followed by the data character that leaves the far-end comma detector with a correctly polarised comma.

Top module: `disparity_predictor`

## Requirements
- R1: After synchronous reset, `out_vld` is 0 and the carried running disparity is negative. Disparity is encoded as 0 for negative and 1 for positive.
- R2: `out_vld` equals `in_vld` from the previous cycle. For a non-idle word, `out_data` and `out_k` equal the previous cycle's `in_data` and `in_k`.
- R3: `out_rd_lo` always equals the carried running disparity, which is the end-of-word disparity of the last valid word (or negative after reset).
- R4: `out_rd_hi` equals `out_rd_lo` XOR the flip bit of the low byte.
- R5: `out_rd_end` equals `out_rd_hi` XOR the flip bit of the high byte. After a valid output word, the next cycle's `out_rd_lo` equals that word's `out_rd_end`.
- R6: For a data byte (control flag 0), split the byte into x = bits [4:0] and y = bits [7:5]. The 6-bit part is unbalanced for x in {0,1,2,4,8,15,16,23,24,27,29,30,31}. The 4-bit part is unbalanced for y in {0,4,7}. The flip bit is 1 exactly when one part is unbalanced and the other is balanced.
- R7: For a control byte (control flag 1), the same rule applies except that x = 28 also counts as unbalanced. As a result, the comma 0xBC flips, while the data byte 0xBC does not.
- R8: Cycles with `in_vld` low leave the carried running disparity unchanged.
- R9: A valid word with `in_idle` high and positive carried disparity is output as data 0xC5BC with `out_k` = 2'b01, whatever `in_data` holds. Its `out_rd_end` is negative.
- R10: A valid word with `in_idle` high and negative carried disparity is output as data 0x50BC with `out_k` = 2'b01. Its `out_rd_end` is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word valid |
| in_idle | input | 1 | Replace this word with the disparity-matched IDLE |
| in_data | input | 16 | Transmit word, low byte in bits [7:0] |
| in_k | input | 2 | Control flag per byte, bit 0 for the low byte |
| out_vld | output | 1 | Output word valid |
| out_data | output | 16 | Word to encode |
| out_k | output | 2 | Control flags to encode |
| out_rd_lo | output | 1 | Disparity to force on the low byte |
| out_rd_hi | output | 1 | Disparity to force on the high byte |
| out_rd_end | output | 1 | Running disparity after the whole word |

## Verification
Hand-picked bytes separate the four sub-block classes: both parts balanced, both unbalanced, and each mix. Pairing those bytes across lanes shows whether the high byte's forced value follows the low byte's flip. The byte 0xBC is sent once as data and once as a control byte, which shows whether x = 28 is treated specially only for control bytes. Idle requests arrive at both polarities and carry garbage data, so the check confirms that the IDLE choice follows the carried disparity and not the input. Gaps in `in_vld`, followed by a long stretch of random words, show whether the disparity is carried only across valid words.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    localparam int BYTE_W    = 8;
    localparam int LANES     = 2;
    localparam int WORD_W    = BYTE_W * LANES;
    localparam int ADDR_W    = BYTE_W + 1;
    localparam int ROM_DEPTH = 2 ** ADDR_W;

    localparam logic [BYTE_W-1:0] COMMA_CHAR  = 8'hBC;
    localparam logic [BYTE_W-1:0] FILL_POS_RD = 8'hC5;
    localparam logic [BYTE_W-1:0] FILL_NEG_RD = 8'h50;

    typedef enum logic { RD_NEG = 1'b0, RD_POS = 1'b1 } rd_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  k;
        logic              idle;
    } word_t;

    function automatic logic six_unbal(input logic [4:0] x, input logic is_k);
        case (x)
            5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16, 5'd23,
            5'd24, 5'd27, 5'd29, 5'd30, 5'd31: six_unbal = 1'b1;
            5'd28:   six_unbal = is_k;
            default: six_unbal = 1'b0;
        endcase
    endfunction

    function automatic logic four_unbal(input logic [2:0] y);
        four_unbal = (y == 3'd0) || (y == 3'd4) || (y == 3'd7);
    endfunction

    function automatic logic [ROM_DEPTH-1:0] build_flip_rom();
        logic [ROM_DEPTH-1:0] t;
        for (int a = 0; a < ROM_DEPTH; a++) begin
            logic [ADDR_W-1:0] idx;
            idx  = ADDR_W'(a);
            t[a] = six_unbal(idx[4:0], idx[ADDR_W-1]) ^ four_unbal(idx[7:5]);
        end
        return t;
    endfunction
endpackage

// File: rtl/rdp_flip_rom.sv
module rdp_flip_rom
    import rdp_pkg::*;
(
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    output logic              flip_q
);
    localparam logic [ROM_DEPTH-1:0] FLIP_TABLE = build_flip_rom();

    always_ff @(posedge clk) begin
        flip_q <= FLIP_TABLE[addr];
    end
endmodule

// File: rtl/rdp_tracker.sv
module rdp_tracker
    import rdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_q,
    input  word_t             word_q,
    input  logic [LANES-1:0]  flip,
    output logic [WORD_W-1:0] data_o,
    output logic [LANES-1:0]  k_o,
    output logic              rd_lo,
    output logic              rd_hi,
    output logic              rd_end
);
    rd_e              rd_q;
    logic [LANES-1:0] f_eff;

    always_comb begin
        if (word_q.idle) begin
            data_o = {(rd_q == RD_POS) ? FILL_POS_RD : FILL_NEG_RD, COMMA_CHAR};
            k_o    = 2'b01;
            f_eff  = {(rd_q == RD_NEG), 1'b1};
        end else begin
            data_o = word_q.data;
            k_o    = word_q.k;
            f_eff  = flip;
        end
        rd_lo  = rd_q;
        rd_hi  = rd_lo ^ f_eff[0];
        rd_end = rd_hi ^ f_eff[1];
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= RD_NEG;
        else if (vld_q) rd_q <= rd_e'(rd_end);
    end

    // R5
    carry_chain_chk: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> (rd_lo == $past(rd_end)));
    // R8
    hold_when_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_q |=> $stable(rd_lo));
    // R9
    idle_ends_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_q && word_q.idle) |-> (rd_end == 1'b0));
endmodule

// File: rtl/disparity_predictor.sv
module disparity_predictor
    import rdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              in_idle,
    input  logic [WORD_W-1:0] in_data,
    input  logic [LANES-1:0]  in_k,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_data,
    output logic [LANES-1:0]  out_k,
    output logic              out_rd_lo,
    output logic              out_rd_hi,
    output logic              out_rd_end
);
    logic [LANES-1:0] flip;
    logic             vld_q;
    word_t            word_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rdp_flip_rom u_rom (
            .clk    (clk),
            .addr   ({in_k[g], in_data[g*BYTE_W +: BYTE_W]}),
            .flip_q (flip[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= in_vld;
        word_q <= '{data: in_data, k: in_k, idle: in_idle};
    end

    rdp_tracker u_trk (
        .clk    (clk),
        .rst    (rst),
        .vld_q  (vld_q),
        .word_q (word_q),
        .flip   (flip),
        .data_o (out_data),
        .k_o    (out_k),
        .rd_lo  (out_rd_lo),
        .rd_hi  (out_rd_hi),
        .rd_end (out_rd_end)
    );

    assign out_vld = vld_q;

    // R2
    vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    // R2
    no_spurious_vld_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
endmodule

// File: tb/disparity_predictor_test.sv
module disparity_predictor_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld, in_idle;
    logic [15:0] in_data;
    logic [1:0]  in_k;
    logic        out_vld, out_rd_lo, out_rd_hi, out_rd_end;
    logic [15:0] out_data;
    logic [1:0]  out_k;

    int checks = 0;
    int errors = 0;
    int ref_rd = 0;
    bit pend = 0;
    bit p_vld, p_idle;
    logic [15:0] p_data;
    logic [1:0]  p_k;

    always #4 clk = ~clk;

    disparity_predictor uut (.*);

    function automatic int ref_flip(input logic [7:0] b, input logic kf);
        int x, y, u6, u4;
        x  = int'(b[4:0]);
        y  = int'(b[7:5]);
        u6 = (x inside {0, 1, 2, 4, 8, 15, 16, 23, 24, 27, 29, 30, 31}) ? 1 : 0;
        if (kf && x == 28) u6 = 1;
        u4 = (y inside {0, 4, 7}) ? 1 : 0;
        return (u6 != u4) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare outputs for the word driven at the previous falling edge
    task automatic compare();
        int fl, fh, hi, en;
        logic [15:0] ed;
        logic [1:0]  ek;
        chk("R2 vld", out_vld, pend ? p_vld : 0);
        chk("R3 rd_lo", out_rd_lo, ref_rd);
        if (pend && p_vld) begin
            if (p_idle) begin
                ed = (ref_rd == 1) ? 16'hC5BC : 16'h50BC;
                ek = 2'b01;
                fl = 1;
                fh = (ref_rd == 1) ? 0 : 1;
                chk(ref_rd == 1 ? "R9 idle data" : "R10 idle data", out_data, ed);
                chk("R9 R10 idle k", out_k, ek);
            end else begin
                fl = ref_flip(p_data[7:0], p_k[0]);
                fh = ref_flip(p_data[15:8], p_k[1]);
                chk("R2 data", out_data, p_data);
                chk("R2 k", out_k, p_k);
            end
            hi = ref_rd ^ fl;
            en = hi ^ fh;
            chk("R4 R6 R7 rd_hi", out_rd_hi, hi);
            chk("R5 R6 R7 rd_end", out_rd_end, en);
            if (p_idle) chk("R9 R10 idle ends negative", out_rd_end, 0);
            ref_rd = en;
        end
    endtask

    task automatic step(input bit v, input bit idl, input logic [15:0] d, input logic [1:0] k);
        @(negedge clk);
        compare();
        in_vld = v; in_idle = idl; in_data = d; in_k = k;
        p_vld = v; p_idle = idl; p_data = d; p_k = k; pend = 1;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_vld = 0; in_idle = 0; in_data = 0; in_k = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 vld after reset", out_vld, 0);
        chk("R1 rd after reset", out_rd_lo, 0);
        rst = 1'b0;
        step(0, 0, 16'h0000, 2'b00);
        // R6 class mixes: 0x03 flips, 0x00 no flip, 0x63 no flip, 0x05 flips
        step(1, 0, 16'h0003, 2'b00);
        step(1, 0, 16'h0500, 2'b00);
        step(1, 0, 16'h6303, 2'b00);
        // R7 0xBC as data vs control
        step(1, 0, 16'hBCBC, 2'b00);
        step(1, 0, 16'hBCBC, 2'b01);
        step(1, 0, 16'hBCBC, 2'b11);
        // R8 gap with changing inputs
        step(0, 0, 16'h0303, 2'b00);
        step(0, 1, 16'hFFFF, 2'b11);
        // R9 / R10 idles at both polarities, garbage data
        step(1, 0, 16'h0003, 2'b00);
        step(1, 1, 16'h1234, 2'b10);
        step(1, 1, 16'hABCD, 2'b11);
        step(1, 0, 16'h0003, 2'b00);
        step(1, 1, 16'h0000, 2'b00);
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom % 16;
            step(r != 0, r == 1, 16'($urandom), 2'($urandom));
        end
        // R1 reset mid-run restores negative disparity
        step(1, 0, 16'h0003, 2'b00);
        @(negedge clk);
        compare();
        rst = 1'b1; in_vld = 0; pend = 0;
        @(negedge clk);
        ref_rd = 0;
        chk("R1 rd after second reset", out_rd_lo, 0);
        chk("R1 vld after second reset", out_vld, 0);
        rst = 1'b0;
        step(1, 1, 16'h0000, 2'b00);
        step(0, 0, 16'h0000, 2'b00);
        step(0, 0, 16'h0000, 2'b00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule